// File: doc/BRIEF.md
# Schedule Base Time Alignment Unit

This unit prepares the per-port timing for an egress gate scheduler that runs from a synchronized time-of-day clock. Each of up to five ports may carry a schedule. A schedule has a base time and a cycle time, both given in nanoseconds as 64-bit values. After a start strobe the unit finds the earliest and latest base times and the longest cycle time. It advances the earliest base time by whole multiples of its own cycle until it lies in the same window as the latest one. It then confirms that the two are close enough, and computes a nonzero entry-point offset for every active port, counted in 200 ns steps.

All arithmetic is sequential. A single restoring divider yields one quotient bit per clock. It is shared by the alignment step and by the per-port offset steps. The unit avoids wide multipliers by rebuilding each rounded-up time from the divider's remainder. The inputs are captured on the start strobe. The results stay on the outputs until the next run, and a one-cycle done pulse marks the end of each run. Base times, cycle times and their sums are assumed to stay below 2^63.

Top module: `sched_align_unit`

## Requirements
- R1: On reset, busy, done, sched_off, cycle_err and range_err are 0, and aligned_out, latest_out, max_cycle_out and every offset are 0.
- R2: A start while idle captures port_valid, base_flat and cycle_flat, clears all results and flags, and raises busy. Later input changes have no effect on that run, and a start while busy is ignored.
- R3: If no port is marked valid, the run ends with sched_off = 1 and all offsets at 0.
- R4: If any valid port has a cycle time of 0, the run ends with cycle_err = 1, no division starts, and all offsets are 0.
- R5: latest_out is the largest base time and max_cycle_out is the largest cycle time, both taken over valid ports only. Invalid ports are ignored even if they hold larger values.
- R6: The earliest base time is taken from the lowest-indexed valid port when two ports tie. It is moved forward to base + n*cycle with n = ceil((latest - base) / cycle), using that port's own cycle. It is then moved back one cycle at a time while it exceeds latest_out. The result is aligned_out.
- R7: If latest_out - aligned_out exceeds 2^19 * 200 ns = 104857600 ns, the run ends with range_err = 1 and all offsets at 0. A spread of exactly that amount is accepted.
- R8: Port p's offset sits in delta_flat[p*64 +: 64]. For a valid port, the relative time is the port's base moved forward by whole cycles to the first value at or after aligned_out, minus aligned_out. The offset is floor(relative / 200) + 1. An invalid port's offset is 0.
- R9: done is high for exactly one cycle at the end of every run. busy is low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| port_valid | input | NPORT | Per-port schedule present |
| base_flat | input | NPORT*W | Per-port base time in ns, port p at [p*W +: W] |
| cycle_flat | input | NPORT*W | Per-port cycle time in ns, port p at [p*W +: W] |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| sched_off | output | 1 | No valid port |
| cycle_err | output | 1 | A valid port has a zero cycle |
| range_err | output | 1 | Base time spread too large |
| aligned_out | output | W | Earliest base time after alignment |
| latest_out | output | W | Latest base time |
| max_cycle_out | output | W | Longest cycle time |
| delta_flat | output | NPORT*W | Per-port entry offsets in 200 ns units |

## Verification
The hardest case to reach is a tie for the earliest base time between ports with different cycles. The chosen port's cycle decides both the ceiling step and the step-back. The stimulus therefore sets two ports to the same base time with cycles of 300 us and 700 us, so that each choice gives a different aligned value. The spread limit is hit exactly and one nanosecond beyond it. A second start is issued mid-run with changed inputs to show that the captured run is unaffected.

// File: rtl/sched_align_unit.sv
module sched_align_unit #(
  parameter int NPORT       = 5,
  parameter int W           = 64,
  parameter int DELTA_NS    = 200,
  parameter int SPREAD_LOG2 = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NPORT-1:0]   port_valid,
  input  logic [NPORT*W-1:0] base_flat,
  input  logic [NPORT*W-1:0] cycle_flat,
  output logic               busy,
  output logic               done,
  output logic               sched_off,
  output logic               cycle_err,
  output logic               range_err,
  output logic [W-1:0]       aligned_out,
  output logic [W-1:0]       latest_out,
  output logic [W-1:0]       max_cycle_out,
  output logic [NPORT*W-1:0] delta_flat
);
  localparam int IW = $clog2(NPORT + 1);
  localparam int CW = $clog2(W);
  localparam logic [W-1:0] LIMIT = W'((64'd1 << SPREAD_LOG2) * DELTA_NS);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_DIV, S_STEP, S_CHECK, S_PORT, S_FIN} st_t;
  typedef enum logic [1:0] {P_ALIGN, P_REL, P_DELTA} ph_t;

  st_t st;
  ph_t ph;
  logic [NPORT-1:0] v_q;
  logic [W-1:0] b_q [NPORT];
  logic [W-1:0] c_q [NPORT];
  logic [W-1:0] delta_q [NPORT];
  logic [W-1:0] ecyc, dq, dr, dd;
  logic [CW-1:0] dcnt;
  logic [IW-1:0] idx;

  logic         s_any, s_zero;
  logic [W-1:0] s_min, s_max, s_cmax, s_ecyc;

  always_comb begin
    s_any = 1'b0; s_zero = 1'b0;
    s_min = '0; s_max = '0; s_cmax = '0; s_ecyc = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (v_q[p]) begin
        if (!s_any || b_q[p] < s_min) begin
          s_min  = b_q[p];
          s_ecyc = c_q[p];
        end
        if (b_q[p] > s_max)  s_max  = b_q[p];
        if (c_q[p] > s_cmax) s_cmax = c_q[p];
        if (c_q[p] == '0)    s_zero = 1'b1;
        s_any = 1'b1;
      end
    end
  end

  logic [W:0]   d_sh;
  logic         d_ge;
  logic [W-1:0] r_nx, q_nx, pb, pc;
  assign d_sh = {dr, dq[W-1]};
  assign d_ge = d_sh >= {1'b0, dd};
  assign r_nx = d_ge ? W'(d_sh - {1'b0, dd}) : d_sh[W-1:0];
  assign q_nx = {dq[W-2:0], d_ge};
  assign pb   = b_q[idx];
  assign pc   = c_q[idx];

  assign busy = st != S_IDLE;
  assign done = st == S_FIN;

  for (genvar g = 0; g < NPORT; g++) begin : g_out
    assign delta_flat[g*W +: W] = delta_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_ALIGN; v_q <= '0;
      ecyc <= '0; dq <= '0; dr <= '0; dd <= '0; dcnt <= '0; idx <= '0;
      sched_off <= 1'b0; cycle_err <= 1'b0; range_err <= 1'b0;
      aligned_out <= '0; latest_out <= '0; max_cycle_out <= '0;
      for (int p = 0; p < NPORT; p++) begin
        b_q[p] <= '0; c_q[p] <= '0; delta_q[p] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (start) begin
          v_q <= port_valid;
          for (int p = 0; p < NPORT; p++) begin
            b_q[p] <= base_flat[p*W +: W];
            c_q[p] <= cycle_flat[p*W +: W];
            delta_q[p] <= '0;
          end
          sched_off <= 1'b0; cycle_err <= 1'b0; range_err <= 1'b0;
          aligned_out <= '0; latest_out <= '0; max_cycle_out <= '0;
          st <= S_SCAN;
        end
        S_SCAN: begin
          if (!s_any) begin
            sched_off <= 1'b1; st <= S_FIN;
          end else if (s_zero) begin
            cycle_err <= 1'b1; st <= S_FIN;
          end else begin
            latest_out <= s_max; max_cycle_out <= s_cmax;
            ecyc <= s_ecyc; aligned_out <= s_min;
            if (s_min >= s_max) st <= S_STEP;
            else begin
              dq <= s_max - s_min + s_ecyc - 1'b1;
              dr <= '0; dd <= s_ecyc; dcnt <= '0;
              ph <= P_ALIGN; st <= S_DIV;
            end
          end
        end
        S_DIV: begin
          dq <= q_nx; dr <= r_nx; dcnt <= dcnt + 1'b1;
          if (dcnt == CW'(W - 1)) begin
            dcnt <= '0; dr <= '0;
            case (ph)
              P_ALIGN: begin
                aligned_out <= latest_out + ecyc - 1'b1 - r_nx;
                st <= S_STEP;
              end
              P_REL: begin
                dq <= pc - 1'b1 - r_nx;
                dd <= W'(DELTA_NS);
                ph <= P_DELTA;
              end
              default: begin
                delta_q[idx] <= q_nx + 1'b1;
                idx <= idx + 1'b1;
                st <= S_PORT;
              end
            endcase
          end
        end
        S_STEP:
          if (aligned_out > latest_out) aligned_out <= aligned_out - ecyc;
          else st <= S_CHECK;
        S_CHECK:
          if (latest_out - aligned_out > LIMIT) begin
            range_err <= 1'b1; st <= S_FIN;
          end else begin
            idx <= '0; st <= S_PORT;
          end
        S_PORT:
          if (idx == IW'(NPORT)) st <= S_FIN;
          else if (!v_q[idx]) idx <= idx + 1'b1;
          else begin
            dr <= '0; dcnt <= '0; st <= S_DIV;
            if (pb >= aligned_out) begin
              dq <= pb - aligned_out; dd <= W'(DELTA_NS); ph <= P_DELTA;
            end else begin
              dq <= aligned_out - pb + pc - 1'b1; dd <= pc; ph <= P_REL;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sched_align_chk.sv
module sched_align_chk #(
  parameter int NPORT       = 5,
  parameter int W           = 64,
  parameter int DELTA_NS    = 200,
  parameter int SPREAD_LOG2 = 19
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               sched_off,
  input logic               cycle_err,
  input logic               range_err,
  input logic [NPORT-1:0]   port_valid,
  input logic [W-1:0]       aligned_out,
  input logic [W-1:0]       latest_out,
  input logic [NPORT*W-1:0] delta_flat
);
  localparam logic [W-1:0] LIMIT = W'((64'd1 << SPREAD_LOG2) * DELTA_NS);

  logic [NPORT-1:0] cap_v;
  logic             ok_end;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cap_v <= '0;
    else if (start && !busy) cap_v <= port_valid;
  assign ok_end = done && !sched_off && !cycle_err && !range_err;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R7
  spread_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_end |-> (latest_out >= aligned_out && latest_out - aligned_out <= LIMIT));
  // R7
  spread_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && range_err) |-> (latest_out - aligned_out > LIMIT));
  // R3
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sched_off) |-> (delta_flat == '0));

  for (genvar g = 0; g < NPORT; g++) begin : g_nz
    // R8
    delta_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_end && cap_v[g]) |-> (delta_flat[g*W +: W] != '0));
  end
endmodule

bind sched_align_unit sched_align_chk #(
  .NPORT(NPORT), .W(W), .DELTA_NS(DELTA_NS), .SPREAD_LOG2(SPREAD_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sched_off(sched_off), .cycle_err(cycle_err), .range_err(range_err),
  .port_valid(port_valid), .aligned_out(aligned_out), .latest_out(latest_out),
  .delta_flat(delta_flat)
);

// File: tb/test_sched_align_unit.sv
module test_sched_align_unit;
  localparam int NP = 5;
  localparam logic [63:0] LIM = 64'd104857600;
  localparam int NV = 5;
  localparam logic [4:0] TV [NV] = '{5'b00011, 5'b11111, 5'b00000, 5'b00100, 5'b00011};
  localparam logic [63:0] TB [NV][NP] = '{
    '{64'd1000000000, 64'd1000300000, 64'd0, 64'd0, 64'd0},
    '{64'd5000000123, 64'd4000000000, 64'd5000001000, 64'd4999999000, 64'd5000000000},
    '{64'd7, 64'd8, 64'd9, 64'd10, 64'd11},
    '{64'd0, 64'd0, 64'd500, 64'd0, 64'd0},
    '{64'd0, 64'd500000000, 64'd0, 64'd0, 64'd0}};
  localparam logic [63:0] TC [NV][NP] = '{
    '{64'd500000, 64'd1000000, 64'd0, 64'd0, 64'd0},
    '{64'd1000000, 64'd250000, 64'd500000, 64'd2000000, 64'd1000000},
    '{64'd100, 64'd100, 64'd100, 64'd100, 64'd100},
    '{64'd1000, 64'd1000, 64'd0, 64'd1000, 64'd1000},
    '{64'd1000000000, 64'd1000000000, 64'd0, 64'd0, 64'd0}};
  // expected outcome: 0 ok, 1 no port, 2 zero cycle, 3 spread too large
  localparam logic [1:0] TE [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd3};

  logic clk = 0, rst_n = 0, start = 0;
  logic [NP-1:0] tv = '0;
  logic [63:0] tb_ [NP];
  logic [63:0] tc_ [NP];
  logic [NP*64-1:0] base_flat, cycle_flat, delta_flat;
  logic busy, done, sched_off, cycle_err, range_err;
  logic [63:0] aligned_out, latest_out, max_cycle_out;
  int n_chk = 0, n_bad = 0;
  logic e_off, e_cerr, e_rerr;
  logic [63:0] e_al, e_lat, e_max;
  logic [63:0] e_d [NP];

  always #5 clk = ~clk;

  always_comb
    for (int p = 0; p < NP; p++) begin
      base_flat[p*64 +: 64]  = tb_[p];
      cycle_flat[p*64 +: 64] = tc_[p];
    end

  sched_align_unit i_sched_align_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .port_valid(tv),
    .base_flat(base_flat), .cycle_flat(cycle_flat), .busy(busy), .done(done),
    .sched_off(sched_off), .cycle_err(cycle_err), .range_err(range_err),
    .aligned_out(aligned_out), .latest_out(latest_out),
    .max_cycle_out(max_cycle_out), .delta_flat(delta_flat));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] fut(input logic [63:0] b, input logic [63:0] c, input logic [63:0] now);
    if (b >= now) return b;
    return b + ((now - b + c - 1) / c) * c;
  endfunction

  task automatic model();
    bit any = 0;
    int ei = 0;
    logic [63:0] emin = 0, lat = 0, mc = 0;
    e_off = 0; e_cerr = 0; e_rerr = 0; e_al = 0; e_lat = 0; e_max = 0;
    for (int p = 0; p < NP; p++) e_d[p] = 0;
    for (int p = 0; p < NP; p++)
      if (tv[p]) begin
        if (!any || tb_[p] < emin) begin emin = tb_[p]; ei = p; end
        any = 1;
        if (tb_[p] > lat) lat = tb_[p];
        if (tc_[p] > mc) mc = tc_[p];
        if (tc_[p] == 0) e_cerr = 1;
      end
    if (!any) begin e_off = 1; return; end
    if (e_cerr) return;
    e_lat = lat; e_max = mc;
    e_al = fut(emin, tc_[ei], lat);
    while (e_al > lat) e_al = e_al - tc_[ei];
    if (lat - e_al > LIM) begin e_rerr = 1; return; end
    for (int p = 0; p < NP; p++)
      if (tv[p]) e_d[p] = (fut(tb_[p], tc_[p], e_al) - e_al) / 200 + 1;
  endtask

  task automatic load(input int k);
    tv = TV[k];
    for (int p = 0; p < NP; p++) begin tb_[p] = TB[k][p]; tc_[p] = TC[k][p]; end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic compare_all();
    chk("R3 sched_off", 64'(sched_off), 64'(e_off));
    chk("R4 cycle_err", 64'(cycle_err), 64'(e_cerr));
    chk("R7 range_err", 64'(range_err), 64'(e_rerr));
    if (!e_off && !e_cerr) begin
      chk("R6 aligned", aligned_out, e_al);
      chk("R5 latest", latest_out, e_lat);
      chk("R5 max cycle", max_cycle_out, e_max);
    end
    for (int p = 0; p < NP; p++) chk("R8 delta", delta_flat[p*64 +: 64], e_d[p]);
    @(negedge clk);
    chk("R9 done pulse", 64'(done), 64'd0);
    chk("R9 busy low", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin tb_[p] = 0; tc_[p] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 flags", 64'({sched_off, cycle_err, range_err}), 0);
    chk("R1 aligned", aligned_out, 0);
    chk("R1 delta", delta_flat[63:0], 0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      load(k);
      model();
      chk("R3 R4 R7 table outcome", 64'({e_off, e_cerr, e_rerr}),
          64'(TE[k] == 2'd1 ? 3'b100 : TE[k] == 2'd2 ? 3'b010 : TE[k] == 2'd3 ? 3'b001 : 3'b000));
      pulse_start();
      chk("R2 busy after start", 64'(busy), 1);
      wait_done();
      compare_all();
    end

    // R6 tie on earliest base: lowest index wins, its cycle 300 us
    tv = 5'b11010;
    tb_[0] = 0; tc_[0] = 0; tb_[2] = 0; tc_[2] = 0;
    tb_[1] = 64'd1000000; tc_[1] = 64'd300000;
    tb_[3] = 64'd1000000; tc_[3] = 64'd700000;
    tb_[4] = 64'd2000000; tc_[4] = 64'd1000000;
    model();
    pulse_start(); wait_done();
    chk("R6 tie aligned", aligned_out, 64'd1900000);
    compare_all();

    // R7 boundary: spread exactly the limit is accepted
    tv = 5'b00011;
    for (int p = 0; p < NP; p++) begin tb_[p] = 0; tc_[p] = 0; end
    tc_[0] = 64'd1000000000; tb_[1] = LIM; tc_[1] = 64'd1000000000;
    model();
    pulse_start(); wait_done();
    chk("R7 at limit accepted", 64'(range_err), 0);
    chk("R8 delta at limit", delta_flat[127:64], 64'd524289);
    compare_all();

    // R7 one ns past the limit
    tb_[1] = LIM + 1;
    model();
    pulse_start(); wait_done();
    chk("R7 past limit", 64'(range_err), 1);
    compare_all();

    // R5 invalid port with huge values is ignored
    tv = 5'b00001; tb_[0] = 64'd5000; tc_[0] = 64'd1000;
    tb_[4] = 64'd900000000; tc_[4] = 64'd900000000;
    model();
    pulse_start(); wait_done();
    chk("R5 latest ignores invalid", latest_out, 64'd5000);
    chk("R8 single port delta", delta_flat[63:0], 64'd1);
    compare_all();

    // R2 start and input change during a run are ignored
    load(0);
    model();
    pulse_start();
    repeat (3) @(negedge clk);
    load(4);
    pulse_start();
    wait_done();
    compare_all();
    repeat (2) @(negedge clk);
    chk("R2 no second run", 64'(busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule